// File: doc/BRIEF.md
# Copy Tail Chunk Sequencer

This block moves the few bytes left over once the bulk part of a block copy has finished. It is given a source pointer, a destination pointer and a leftover length from 0 to 31 bytes. It breaks the length into power-of-two pieces and issues one read and then one write for each piece. A 16-byte piece is carried as two 8-byte words. After every word, both pointers move forward by that word's size.

The pieces always go out from largest to smallest: 16, then 8, 4, 2 and 1 byte. A piece is issued only when its bit is set in the length. Each write carries the data returned by the read just before it. A one-cycle done pulse marks the end of the sequence. A length of zero issues no transfer and pulses done straight away.

The memory side has two parts. A read request is held until it is granted and its data comes back later with a valid strobe. A write request carries an address, a size code and data, and is held until it is granted.

Top module: `tail_copy_seq`

## Requirements
- R1: A start accepted with length 0 issues no read and no write. done is high in the first cycle after the accepting clock edge.
- R2: Transfers follow the length's set bits in strictly descending order: 16, 8, 4, 2, 1. A bit that is clear produces no transfer.
- R3: A 16-byte piece is issued as two 8-byte transfers, at offsets 0 and 8 from the piece's start.
- R4: The size field encodes log2 of the byte count: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. Read and write of one transfer carry the same code.
- R5: The read address of each transfer is the start source plus the bytes already moved. The write address is the start destination plus the same count.
- R6: No write is requested before the data of its read has returned. The write data holds the returned bytes in its low byte lanes, little-endian, with every lane above the size set to zero.
- R7: A read or write request stays high with unchanged address, size and data until it is granted. A read request and a write request are never high in the same cycle.
- R8: done is a single-cycle pulse in the cycle after the last write is granted. start_ready is low while a sequence runs, so a start offered then is not taken and does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start offered |
| start_ready | output | 1 | Block idle; start taken when both are high |
| start_src | input | ADDR_W | Source pointer of the tail |
| start_dst | input | ADDR_W | Destination pointer of the tail |
| start_len | input | LEN_W | Leftover byte count, 0 to 31 |
| rd_req | output | 1 | Read request |
| rd_gnt | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read size code (log2 bytes) |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | DATA_W | Read data, little-endian lanes |
| wr_req | output | 1 | Write request |
| wr_gnt | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_size | output | 2 | Write size code (log2 bytes) |
| wr_data | output | DATA_W | Write data, unused lanes zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every length from 0 to 31 is run, at unaligned pointers. This separates a correct binary split from one that drops or reorders bits, and the lengths 16 to 31 show whether the 16-byte piece is split into two words. The lengths 0, 1, 16 and 31 on their own check the empty sequence, the single-byte case, a lone double word and the full five-step order. Returned read data carries filler in the lanes above the size, so a write that fails to clear those lanes is caught. Grants and read latency vary from cycle to cycle, and a start offered during a busy run shows whether requests are held and stray starts are refused.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD    = 2'd1,
      ST_RWAIT = 2'd2,
      ST_WR    = 2'd3
   } tcs_state_e;

   localparam int SIZE_W = 2;
endpackage

// File: rtl/tcs_chunk_pick.sv
module tcs_chunk_pick #(
   parameter int LEN_W   = 5,
   parameter int BEAT_LG = 3,
   parameter int SIZE_W  = 2
) (
   input  logic [LEN_W-1:0]  rem,
   output logic [SIZE_W-1:0] size_code,
   output logic [LEN_W-1:0]  beat_bytes
);
   localparam int BEAT_BYTES = 1 << BEAT_LG;

   // A remaining count at or above one beat always moves a full beat; this
   // splits a 16-byte piece into two beats without a separate state.
   always_comb begin
      size_code  = '0;
      beat_bytes = '0;
      if (rem >= LEN_W'(BEAT_BYTES)) begin
         size_code  = SIZE_W'(BEAT_LG);
         beat_bytes = LEN_W'(BEAT_BYTES);
      end else begin
         for (int b = 0; b < BEAT_LG; b++) begin
            if (rem[b]) begin
               size_code  = SIZE_W'(b);
               beat_bytes = LEN_W'(1 << b);
            end
         end
      end
   end
endmodule

// File: rtl/tcs_lane_mask.sv
module tcs_lane_mask #(
   parameter int DATA_W = 64,
   parameter int SIZE_W = 2
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SIZE_W-1:0] size_code,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic keep;
      assign keep = (i < (1 << size_code));
      assign dout[i*8 +: 8] = keep ? din[i*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/tcs_ptr_pair.sv
module tcs_ptr_pair #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_src,
   input  logic [ADDR_W-1:0] ld_dst,
   input  logic              adv,
   input  logic [LEN_W-1:0]  step,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst
);
   logic [ADDR_W-1:0] step_x;
   assign step_x = ADDR_W'(step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
      end else if (load) begin
         src <= ld_src;
         dst <= ld_dst;
      end else if (adv) begin
         src <= src + step_x;
         dst <= dst + step_x;
      end
   end

   // R5: both pointers move together, so their distance only changes on load
   a_r5_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!load) |-> ((dst - src) == $past(dst - src)));
endmodule

// File: rtl/tail_copy_seq.sv
module tail_copy_seq
   import tcs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   output logic              start_ready,
   input  logic [ADDR_W-1:0] start_src,
   input  logic [ADDR_W-1:0] start_dst,
   input  logic [LEN_W-1:0]  start_len,
   output logic              rd_req,
   input  logic              rd_gnt,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [SIZE_W-1:0] rd_size,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_req,
   input  logic              wr_gnt,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SIZE_W-1:0] wr_size,
   output logic [DATA_W-1:0] wr_data,
   output logic              done
);
   localparam int BEAT_LG = $clog2(DATA_W / 8);

   if (DATA_W != 64) begin : g_chk_data
      $error("tail_copy_seq: DATA_W must be 64");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_chk_len
      $error("tail_copy_seq: LEN_W out of range");
   end
   if (ADDR_W < LEN_W) begin : g_chk_addr
      $error("tail_copy_seq: ADDR_W narrower than LEN_W");
   end

   tcs_state_e        state;
   logic [LEN_W-1:0]  rem;
   logic [DATA_W-1:0] data_q;
   logic              done_q;
   logic [SIZE_W-1:0] size_code;
   logic [LEN_W-1:0]  beat_bytes;
   logic [DATA_W-1:0] masked;
   logic              take_start;
   logic              wr_fire;
   logic              last_beat;

   tcs_chunk_pick #(.LEN_W(LEN_W), .BEAT_LG(BEAT_LG), .SIZE_W(SIZE_W)) u_pick (
      .rem       (rem),
      .size_code (size_code),
      .beat_bytes(beat_bytes)
   );

   tcs_lane_mask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_mask (
      .din      (rd_data),
      .size_code(size_code),
      .dout     (masked)
   );

   assign start_ready = (state == ST_IDLE);
   assign take_start  = start_valid && start_ready;
   assign wr_fire     = (state == ST_WR) && wr_gnt;
   assign last_beat   = (rem == beat_bytes);

   tcs_ptr_pair #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take_start),
      .ld_src(start_src),
      .ld_dst(start_dst),
      .adv   (wr_fire),
      .step  (beat_bytes),
      .src   (rd_addr),
      .dst   (wr_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         rem    <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (take_start) begin
                  rem <= start_len;
                  if (start_len == '0) done_q <= 1'b1;
                  else                 state  <= ST_RD;
               end
            end
            ST_RD: begin
               if (rd_gnt) state <= ST_RWAIT;
            end
            ST_RWAIT: begin
               if (rd_valid) begin
                  data_q <= masked;
                  state  <= ST_WR;
               end
            end
            ST_WR: begin
               if (wr_gnt) begin
                  rem <= rem - beat_bytes;
                  if (last_beat) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_RD;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rd_req  = (state == ST_RD);
   assign rd_size = size_code;
   assign wr_req  = (state == ST_WR);
   assign wr_size = size_code;
   assign wr_data = data_q;
   assign done    = done_q;

   // R7: one request kind at a time
   a_r7_one_req: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));
   // R7: an ungranted read holds its address and size
   a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_size)));
   // R7: an ungranted write holds address, size and data
   a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_size) && $stable(wr_data)));
   // R6: a write only starts once read data has been returned
   a_r6_wr_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_req) |-> $past(rd_valid));
   // R2: the next read after a non-final write is never larger
   a_r2_descend: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !last_beat) |=> (rd_req && rd_size <= $past(wr_size)));
   // R8: done never overlaps a request, and no start is taken while busy
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rd_req && !wr_req && start_ready));
   a_r8_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || wr_req) |-> !start_ready);
endmodule

// File: tb/sim_tail_copy_seq.sv
module sim_tail_copy_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0;
   logic        start_ready;
   logic [31:0] start_src = '0;
   logic [31:0] start_dst = '0;
   logic [4:0]  start_len = '0;
   logic        rd_req;
   logic        rd_gnt = 1'b0;
   logic [31:0] rd_addr;
   logic [1:0]  rd_size;
   logic        rd_valid = 1'b0;
   logic [63:0] rd_data = '0;
   logic        wr_req;
   logic        wr_gnt = 1'b0;
   logic [31:0] wr_addr;
   logic [1:0]  wr_size;
   logic [63:0] wr_data;
   logic        done;

   always #5 clk = ~clk;

   tail_copy_seq u0 (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .start_src(start_src), .start_dst(start_dst), .start_len(start_len),
      .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr), .rd_size(rd_size),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_req(wr_req), .wr_gnt(wr_gnt), .wr_addr(wr_addr), .wr_size(wr_size),
      .wr_data(wr_data), .done(done)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // reference state
   int          eq_off[$];
   int          eq_n[$];
   logic [31:0] base_src, base_dst;
   bit          done_pend = 0;
   int          rd_cnt = 0;
   logic [31:0] r_addr;
   int          r_n;
   logic [15:0] lf = 16'hACE1;

   function automatic logic [7:0] sb(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd7 + 32'd3;
      return t[7:0];
   endfunction

   function automatic int lg2(input int n);
      return (n == 8) ? 3 : (n == 4) ? 2 : (n == 2) ? 1 : 0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected transfer list from the requirements (R2, R3)
   task automatic build(input int len);
      int off = 0;
      eq_off.delete(); eq_n.delete();
      for (int c = 16; c >= 1; c = c / 2) begin
         if ((len & c) != 0) begin
            if (c == 16) begin
               eq_off.push_back(off);     eq_n.push_back(8);
               eq_off.push_back(off + 8); eq_n.push_back(8);
            end else begin
               eq_off.push_back(off);     eq_n.push_back(c);
            end
            off += c;
         end
      end
   endtask

   // Monitor and memory model, evaluated at every falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            // R8 / R1: done only where the model expects it
            chk(done == done_pend, "R8 done timing", 64'(done), 64'(done_pend));
            if (done) chk(eq_off.size() == 0, "R2 transfers left at done", 64'(eq_off.size()), 64'd0);
            done_pend = 0;
            chk(!(rd_req && wr_req), "R7 read and write together", 64'(rd_req && wr_req), 64'd0);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            // read data return after a variable delay
            rd_valid = 1'b0;
            if (rd_cnt > 0) begin
               rd_cnt--;
               if (rd_cnt == 0) begin
                  rd_valid = 1'b1;
                  for (int k = 0; k < 8; k++)
                     rd_data[k*8 +: 8] = (k < r_n) ? sb(r_addr + 32'(k)) : 8'hEE;
               end
            end
            // read request
            rd_gnt = rd_req && lf[0];
            if (rd_req && rd_gnt) begin
               if (eq_off.size() == 0) begin
                  chk(0, "R2 unexpected read", 64'(rd_addr), 64'd0);
               end else begin
                  chk(rd_addr == base_src + 32'(eq_off[0]), "R5 read address", 64'(rd_addr), 64'(base_src + 32'(eq_off[0])));
                  chk(rd_size == 2'(lg2(eq_n[0])), "R4 read size", 64'(rd_size), 64'(lg2(eq_n[0])));
                  r_addr = rd_addr; r_n = eq_n[0];
                  rd_cnt = 1 + int'(lf[3:2]);
               end
            end
            // write request
            wr_gnt = wr_req && lf[1];
            if (wr_req && wr_gnt) begin
               if (eq_off.size() == 0) begin
                  chk(0, "R2 unexpected write", 64'(wr_addr), 64'd0);
               end else begin
                  logic [63:0] ed;
                  int n;
                  n = eq_n[0];
                  for (int k = 0; k < 8; k++)
                     ed[k*8 +: 8] = (k < n) ? sb(base_src + 32'(eq_off[0] + k)) : 8'h00;
                  chk(wr_addr == base_dst + 32'(eq_off[0]), "R3/R5 write address", 64'(wr_addr), 64'(base_dst + 32'(eq_off[0])));
                  chk(wr_size == 2'(lg2(n)), "R4 write size", 64'(wr_size), 64'(lg2(n)));
                  chk(wr_data == ed, "R6 write data", wr_data, ed);
                  void'(eq_off.pop_front()); void'(eq_n.pop_front());
                  if (eq_off.size() == 0) done_pend = 1;
               end
            end
            // start acceptance
            if (start_valid && start_ready) begin
               build(int'(start_len));
               base_src = start_src; base_dst = start_dst;
               if (start_len == 0) done_pend = 1;
            end
         end
      end
   end

   task automatic run(input logic [31:0] s, input logic [31:0] d, input int len, input bit junk);
      @(posedge clk); #2;
      start_valid = 1'b1; start_src = s; start_dst = d; start_len = 5'(len);
      do @(negedge clk); while (!start_ready);
      @(posedge clk); #2;
      if (junk) begin
         // R8: a start offered while busy is refused and changes nothing
         start_src = 32'hDEAD0000; start_dst = 32'hBEEF0000; start_len = 5'd7;
         for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            chk(start_ready == 1'b0, "R8 start_ready while busy", 64'(start_ready), 64'd0);
         end
         @(posedge clk); #2;
      end
      start_valid = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      @(negedge clk);
      chk(start_ready == 1'b1, "R8 reset start_ready", 64'(start_ready), 64'd1);
      chk(rd_req == 1'b0, "R7 reset rd_req", 64'(rd_req), 64'd0);
      chk(wr_req == 1'b0, "R7 reset wr_req", 64'(wr_req), 64'd0);
      chk(done == 1'b0, "R8 reset done", 64'(done), 64'd0);
      rst_n = 1'b1;
      run(32'h0000_1000, 32'h0000_8000, 0, 0);   // R1
      run(32'h0000_1001, 32'h0000_9003, 31, 0);  // R2 full order
      run(32'h0000_2000, 32'h0000_A000, 16, 0);  // R3 two beats
      run(32'h0000_2005, 32'h0000_A00B, 24, 0);  // R3 then 8
      run(32'h0000_3002, 32'h0000_B001, 5, 0);   // R2 skip steps
      run(32'h0000_3007, 32'h0000_B00F, 1, 0);   // R4 byte
      run(32'h0000_4003, 32'h0000_C006, 21, 1);  // R8 busy start
      for (int i = 0; i < 32; i++)
         run(32'h0001_0003 + 32'(i * 64), 32'h0002_0005 + 32'(i * 96), i, 0);
      run(32'hFFFF_FFF0, 32'h0000_0010, 0, 0);   // R1 again after traffic
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule